// File: doc/BRIEF.md
# Partitioned Row Broadcast and Shift Engine

This block is a cycle-accurate digital model of one storage row cut into `K` partitions. Each partition holds `NSLOT` single-bit slots. A chain of `K-1` isolation switches joins neighbouring partitions, and each switch is either conducting or isolating. A command executes as a series of row operations, one per clock. Within one row operation, every segment of partitions joined by conducting switches moves one bit independently of the other segments.

Three commands are supported:

- **Broadcast** replicates the bit held by partition 0 into every partition. It halves the active segments recursively, so it needs log2 K row cycles. With an optional inverting copy, each partition also records the polarity of the bit it ends up holding.
- **Shift** moves a slot of partition p into a slot of partition p+1. It takes two row cycles: first from even partitions to odd ones, then from odd partitions to even ones.
- **Gate-shift** has the same two-phase schedule as shift, but writes a three-input logic function of partition p's slots 0 to 2.

The row is loaded in parallel while the block is idle. The whole row, the polarity flags and the switch states are visible at the ports.

Top module: `part_row_engine`

## Requirements
- R1: After reset, `busy`, `done` and `op_cycles` are 0, every slot and polarity flag is 0, and every switch reads isolating (`iso_q` bit = 1).
- R2: With the block idle, `load_en` copies `load_row` into the row (slot s of partition p sits at bit p*NSLOT+s) and clears all polarity flags. A load presented while `busy` is high has no effect.
- R3: Broadcast (op code 01) writes slot `dst_slot` of every partition p≥1 from slot `dst_slot` of partition 0. It takes exactly log2 K row cycles.
- R4: With `inv_copy`=1, broadcast leaves partition p holding b XOR q(p), where q(p) is the parity of the number of one bits in p. It also sets `pol_q[p]` = q(p). With `inv_copy`=0, every `pol_q[p]` for p≥1 becomes 0.
- R5: In broadcast row cycle s (counted from 0), switch j (between partitions j and j+1) is isolating exactly when (j+1) is a multiple of K>>s.
- R6: Shift (op code 10) takes exactly two row cycles. For every p≥1, slot `dst_slot` of partition p receives the old slot `src_slot` of partition p-1. Partition 0 and all other slots are unchanged, and the source bit of partition K-1 is dropped.
- R7: During shift and gate-shift, switch j conducts in the first row cycle exactly when j is even, and in the second exactly when j is odd. While idle, every switch isolates.
- R8: Gate-shift (op code 11) writes into slot `dst_slot` of partition p≥1 a function of slots 0, 1 and 2 of partition p-1, in two row cycles. The function is chosen by `gate_sel`: 0 minority, 1 majority, 2 three-input XOR, 3 three-input AND. The caller picks a `dst_slot` of 3 or above.
- R9: A shift with `src_slot` = `dst_slot` sees the first phase's writes in its second phase. Odd p receives the old bit of p-1, and even p≥2 receives the old bit of p-2.
- R10: While the block is idle, a `start` with a nonzero op code raises `busy` on the next cycle for exactly n cycles, where n is the command's row cycle count. `done` then pulses for one cycle with `busy` low, and `op_cycles` equals n. A `start` while `busy` is high, or a `start` with op code 00, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start strobe |
| op | input | 2 | Command code: 01 broadcast, 10 shift, 11 gate-shift |
| src_slot | input | log2 NSLOT | Source slot for shift |
| dst_slot | input | log2 NSLOT | Destination slot for all commands |
| gate_sel | input | 2 | Gate-shift function select |
| inv_copy | input | 1 | Broadcast uses inverting copies |
| load_en | input | 1 | Parallel row load strobe |
| load_row | input | K*NSLOT | Row load data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| op_cycles | output | log2(log2 K+2) | Row cycles used by the last command |
| row_q | output | K*NSLOT | All slots of all partitions |
| pol_q | output | K | Per-partition polarity flags |
| iso_q | output | K-1 | Switch states, 1 = isolating |

## Verification
The bound checker checks the following on every cycle:

- the switch pattern: a broadcast has a segment count of 2^s, a shift phase has a conducting-link count, and the row is fully isolated when idle;
- the one-cycle `done` pulse that ends `busy`, together with the per-command row cycle count;
- the stability of partition 0 during any command.

Only the bench's scenarios can show the data outcomes: the bit in each slot after a broadcast, the parity-driven polarity, shifted and gated values, the same-slot hazard result, and loads or starts ignored while busy.

// File: rtl/pre_pkg.sv
package pre_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_BCAST = 2'b01,
        OP_SHIFT = 2'b10,
        OP_GATE  = 2'b11
    } row_op_e;

    typedef enum logic [1:0] {
        FN_MIN3 = 2'b00,
        FN_MAJ3 = 2'b01,
        FN_XOR3 = 2'b10,
        FN_AND3 = 2'b11
    } gate_fn_e;

    typedef struct packed {
        row_op_e  op;
        gate_fn_e fn;
        logic     inv;
    } cmd_t;

    function automatic logic gate_eval(gate_fn_e f, logic [2:0] v);
        logic maj;
        maj = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
        case (f)
            FN_MIN3: return ~maj;
            FN_MAJ3: return maj;
            FN_XOR3: return ^v;
            default: return &v;
        endcase
    endfunction

endpackage

// File: rtl/pre_ctrl.sv
module pre_ctrl
    import pre_pkg::*;
#(
    parameter int LOGK   = 3,
    parameter int SW     = 2,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cmd_t              cmd_in,
    input  logic [SW-1:0]     src_in,
    input  logic [SW-1:0]     dst_in,
    output logic              run,
    output logic [STEP_W-1:0] step,
    output logic              done,
    output logic [STEP_W-1:0] op_cycles,
    output cmd_t              cmd_q,
    output logic [SW-1:0]     src_q,
    output logic [SW-1:0]     dst_q
);

    logic              accept;
    logic [STEP_W-1:0] nsteps;
    logic              last;

    assign accept = start && !run && (cmd_in.op != OP_NONE);
    assign nsteps = (cmd_q.op == OP_BCAST) ? STEP_W'(LOGK) : STEP_W'(2);
    assign last   = (step == nsteps - STEP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            step      <= '0;
            done      <= 1'b0;
            op_cycles <= '0;
            cmd_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                run       <= 1'b1;
                step      <= '0;
                op_cycles <= '0;
                cmd_q     <= cmd_in;
                src_q     <= src_in;
                dst_q     <= dst_in;
            end else if (run) begin
                op_cycles <= op_cycles + STEP_W'(1);
                if (last) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                    step <= '0;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pre_switch.sv
module pre_switch
    import pre_pkg::*;
#(
    parameter int K      = 8,
    parameter int STEP_W = 3
) (
    input  logic              run,
    input  row_op_e           op,
    input  logic [STEP_W-1:0] step,
    output logic [K-2:0]      iso
);

    for (genvar j = 0; j < K - 1; j++) begin : g_sw
        int span;
        always_comb begin
            span = K >> step;
            if (span == 0) span = 1;
            iso[j] = 1'b1;
            if (run) begin
                if (op == OP_BCAST)
                    iso[j] = (((j + 1) % span) == 0);
                else if (step == '0)
                    iso[j] = ((j % 2) == 1);
                else
                    iso[j] = ((j % 2) == 0);
            end
        end
    end

endmodule

// File: rtl/pre_cell.sv
module pre_cell #(
    parameter int NSLOT = 4,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [NSLOT-1:0] ld_val,
    input  logic             wr,
    input  logic [SW-1:0]    wr_slot,
    input  logic             wr_bit,
    input  logic             pol_we,
    input  logic             pol_val,
    output logic [NSLOT-1:0] slots,
    output logic             pol
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
            pol   <= 1'b0;
        end else if (ld) begin
            slots <= ld_val;
            pol   <= 1'b0;
        end else if (wr) begin
            slots[wr_slot] <= wr_bit;
            if (pol_we) pol <= pol_val;
        end
    end

endmodule

// File: rtl/part_row_engine.sv
module part_row_engine
    import pre_pkg::*;
#(
    parameter int  K      = 8,
    parameter int  NSLOT  = 4,
    localparam int LOGK   = $clog2(K),
    localparam int SW     = $clog2(NSLOT),
    localparam int STEP_W = $clog2(LOGK + 2),
    localparam int ROW_W  = K * NSLOT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [SW-1:0]     src_slot,
    input  logic [SW-1:0]     dst_slot,
    input  logic [1:0]        gate_sel,
    input  logic              inv_copy,
    input  logic              load_en,
    input  logic [ROW_W-1:0]  load_row,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] op_cycles,
    output logic [ROW_W-1:0]  row_q,
    output logic [K-1:0]      pol_q,
    output logic [K-2:0]      iso_q
);

    cmd_t              cmd_in, cmd_q;
    logic              run;
    logic [STEP_W-1:0] step;
    logic [SW-1:0]     src_q, dst_q;
    logic              ld_ok;
    logic [NSLOT-1:0]  slot_a [K];
    logic [K-1:0]      pol_v;

    assign cmd_in = '{op: row_op_e'(op), fn: gate_fn_e'(gate_sel), inv: inv_copy};
    assign ld_ok  = load_en && !run;
    assign busy   = run;
    assign pol_q  = pol_v;

    pre_ctrl #(.LOGK(LOGK), .SW(SW), .STEP_W(STEP_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_in),
        .src_in(src_slot), .dst_in(dst_slot), .run(run), .step(step),
        .done(done), .op_cycles(op_cycles), .cmd_q(cmd_q),
        .src_q(src_q), .dst_q(dst_q)
    );

    pre_switch #(.K(K), .STEP_W(STEP_W)) u_sw (
        .run(run), .op(cmd_q.op), .step(step), .iso(iso_q)
    );

    for (genvar p = 0; p < K; p++) begin : g_part
        logic wr, wb, pw, pv;

        if (p == 0) begin : g_head
            assign wr = 1'b0;
            assign wb = 1'b0;
            assign pw = 1'b0;
            assign pv = 1'b0;
        end else begin : g_body
            int span, half, from;
            always_comb begin
                span = K >> step;
                half = span >> 1;
                from = 0;
                wr   = 1'b0;
                wb   = 1'b0;
                pw   = 1'b0;
                pv   = 1'b0;
                if (run) begin
                    if (cmd_q.op == OP_BCAST) begin
                        if (half > 0 && (p % span) == half) begin
                            from = p - half;
                            wr   = 1'b1;
                            wb   = slot_a[from][dst_q] ^ cmd_q.inv;
                            pw   = 1'b1;
                            pv   = pol_v[from] ^ cmd_q.inv;
                        end
                    end else if ((step == '0 && (p % 2) == 1) ||
                                 (step != '0 && (p % 2) == 0)) begin
                        wr = 1'b1;
                        if (cmd_q.op == OP_SHIFT)
                            wb = slot_a[p-1][src_q];
                        else
                            wb = gate_eval(cmd_q.fn, slot_a[p-1][2:0]);
                    end
                end
            end
        end

        pre_cell #(.NSLOT(NSLOT), .SW(SW)) u_cell (
            .clk(clk), .rst(rst), .ld(ld_ok),
            .ld_val(load_row[p*NSLOT +: NSLOT]),
            .wr(wr), .wr_slot(dst_q), .wr_bit(wb),
            .pol_we(pw), .pol_val(pv),
            .slots(slot_a[p]), .pol(pol_v[p])
        );

        assign row_q[p*NSLOT +: NSLOT] = slot_a[p];
    end

endmodule

// File: rtl/part_row_engine_chk.sv
module part_row_engine_chk
    import pre_pkg::*;
#(
    parameter int  K      = 8,
    parameter int  NSLOT  = 4,
    localparam int LOGK   = $clog2(K),
    localparam int STEP_W = $clog2(LOGK + 2)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [1:0]           op,
    input logic                 busy,
    input logic                 done,
    input logic [STEP_W-1:0]    op_cycles,
    input logic [K*NSLOT-1:0]   row_q,
    input logic [K-2:0]         iso_q
);

    logic [1:0] lat_op;
    logic [7:0] cnt;
    int         exp_n;

    assign exp_n = (lat_op == 2'b01) ? LOGK : 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_op <= 2'b00;
            cnt    <= '0;
        end else if (start && !busy && op != 2'b00) begin
            lat_op <= op;
            cnt    <= '0;
        end else if (busy) begin
            cnt <= cnt + 8'd1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R10
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(cnt) == exp_n && int'(op_cycles) == exp_n)); // R3
    AST_IDLE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&iso_q)); // R7
    AST_SHIFT_LINKS: assert property (@(posedge clk) disable iff (rst)
        (busy && lat_op != 2'b01) |->
            ($countones(~iso_q) == ((cnt == 8'd0) ? K / 2 : K / 2 - 1))); // R7
    AST_BCAST_SEGMENTS: assert property (@(posedge clk) disable iff (rst)
        (busy && lat_op == 2'b01) |->
            ($countones(iso_q) == (1 << cnt) - 1)); // R5
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(row_q[NSLOT-1:0])); // R6

endmodule

bind part_row_engine part_row_engine_chk #(.K(K), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/part_row_engine_tb.sv
module part_row_engine_tb;

    localparam int K = 8;
    localparam int NSLOT = 4;
    localparam int ROW_W = K * NSLOT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [1:0]        src_slot = '0, dst_slot = '0;
    logic [1:0]        gate_sel = '0;
    logic              inv_copy = 1'b0;
    logic              load_en = 1'b0;
    logic [ROW_W-1:0]  load_row = '0;
    logic              busy, done;
    logic [2:0]        op_cycles;
    logic [ROW_W-1:0]  row_q;
    logic [K-1:0]      pol_q;
    logic [K-2:0]      iso_q;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit ended = 0;

    logic [ROW_W-1:0] mrow;
    logic [K-1:0]     mpol;

    always #2.5 clk = ~clk;

    part_row_engine #(.K(K), .NSLOT(NSLOT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .src_slot(src_slot),
        .dst_slot(dst_slot), .gate_sel(gate_sel), .inv_copy(inv_copy),
        .load_en(load_en), .load_row(load_row), .busy(busy), .done(done),
        .op_cycles(op_cycles), .row_q(row_q), .pol_q(pol_q), .iso_q(iso_q)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit parity(int p);
        return bit'($countones(p) % 2);
    endfunction

    function automatic bit gfun(int f, bit a, bit b, bit c);
        int n = int'(a) + int'(b) + int'(c);
        case (f)
            0: return n < 2;
            1: return n >= 2;
            2: return bit'(n % 2);
            default: return n == 3;
        endcase
    endfunction

    function automatic logic [K-2:0] exp_iso(logic [1:0] o, int st);
        logic [K-2:0] e;
        for (int j = 0; j < K - 1; j++) begin
            if (o == 2'b01) e[j] = (((j + 1) % (K >> st)) == 0);
            else if (st == 0) e[j] = ((j % 2) == 1);
            else e[j] = ((j % 2) == 0);
        end
        return e;
    endfunction

    task automatic model_cmd(logic [1:0] o, int s, int d, int f, bit iv);
        logic [ROW_W-1:0] old = mrow;
        bit b = old[d];
        for (int p = 1; p < K; p++) begin
            if (o == 2'b01) begin
                mrow[p*NSLOT+d] = b ^ (iv & parity(p));
                mpol[p] = iv & parity(p);
            end else if (o == 2'b10) begin
                if (s != d || (p % 2) == 1) mrow[p*NSLOT+d] = old[(p-1)*NSLOT+s];
                else mrow[p*NSLOT+d] = old[(p-2)*NSLOT+s];
            end else begin
                mrow[p*NSLOT+d] = gfun(f, old[(p-1)*NSLOT], old[(p-1)*NSLOT+1],
                                       old[(p-1)*NSLOT+2]);
            end
        end
    endtask

    task automatic do_load(logic [ROW_W-1:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_row = v;
        @(negedge clk);
        load_en = 1'b0;
        mrow = v;
        mpol = '0;
        chk(row_q == mrow, "R2 load row", 64'(row_q), 64'(mrow));
        chk(pol_q == '0, "R2 load clears polarity", 64'(pol_q), 64'(0));
    endtask

    task automatic run_cmd(logic [1:0] o, int s, int d, int f, bit iv, string tag);
        int n = 0;
        int expn = (o == 2'b01) ? 3 : 2;
        model_cmd(o, s, d, f, iv);
        @(negedge clk);
        op = o; src_slot = 2'(s); dst_slot = 2'(d); gate_sel = 2'(f); inv_copy = iv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && n < 20) begin
            chk(iso_q == exp_iso(o, n), (o == 2'b01) ? "R5 broadcast switches" : "R7 shift switches",
                64'(iso_q), 64'(exp_iso(o, n)));
            n++;
            @(negedge clk);
        end
        chk(done == 1'b1, "R10 done after busy", 64'(done), 64'(1));
        chk(n == expn, (o == 2'b01) ? "R3 broadcast cycle count" : "R6 shift cycle count",
            64'(n), 64'(expn));
        chk(op_cycles == 3'(expn), "R10 op_cycles", 64'(op_cycles), 64'(expn));
        chk(iso_q == '1, "R7 idle isolated", 64'(iso_q), 64'(7'h7f));
        chk(row_q == mrow, tag, 64'(row_q), 64'(mrow));
        chk(pol_q == mpol, "R4 polarity flags", 64'(pol_q), 64'(mpol));
        @(negedge clk);
        chk(done == 1'b0, "R10 done single pulse", 64'(done), 64'(0));
    endtask

    initial begin
        logic [ROW_W-1:0] seedv;
        int n;
        seedv = ROW_W'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset handshake", {busy, done}, 0);
        chk(op_cycles == 0, "R1 reset op_cycles", 64'(op_cycles), 0);
        chk(row_q == 0, "R1 reset row", 64'(row_q), 0);
        chk(pol_q == 0, "R1 reset polarity", 64'(pol_q), 0);
        chk(iso_q == '1, "R1 reset switches", 64'(iso_q), 64'(7'h7f));
        mrow = '0; mpol = '0;

        // Directed broadcasts
        do_load(32'h0000_0001);
        run_cmd(2'b01, 0, 0, 0, 1'b0, "R3 broadcast one");
        do_load(32'h1111_1110);
        run_cmd(2'b01, 0, 0, 0, 1'b1, "R4 inverting broadcast zero");
        do_load(32'h0000_0004);
        run_cmd(2'b01, 0, 2, 0, 1'b1, "R4 inverting broadcast one");

        // Directed shifts and the discarded top bit
        do_load(32'h8000_0001);
        run_cmd(2'b10, 0, 1, 0, 1'b0, "R6 shift distinct slots");
        chk(row_q[3:0] == 4'h1, "R6 partition 0 unchanged", 64'(row_q[3:0]), 64'h1);
        do_load(32'h1234_5678);
        run_cmd(2'b10, 3, 3, 0, 1'b0, "R9 shift same slot");

        // Directed gate-shifts, every function
        for (int f = 0; f < 4; f++) begin
            do_load(32'h0765_4321);
            run_cmd(2'b11, 0, 3, f, 1'b0, "R8 gate-shift function");
        end

        // op 00 ignored
        @(negedge clk);
        op = 2'b00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 0, "R10 op 00 no busy", 64'(busy), 0);
        @(negedge clk);
        chk(done == 0, "R10 op 00 no done", 64'(done), 0);
        chk(row_q == mrow, "R10 op 00 row unchanged", 64'(row_q), 64'(mrow));

        // start and load while busy are ignored
        do_load(32'h0000_0008);
        model_cmd(2'b01, 0, 3, 0, 1'b0);
        @(negedge clk);
        op = 2'b01; dst_slot = 2'd3; inv_copy = 1'b0; start = 1'b1;
        @(negedge clk);
        op = 2'b10; start = 1'b1; load_en = 1'b1; load_row = 32'hFFFF_FFFF;
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
            start = 1'b0; load_en = 1'b0;
        end
        chk(n == 3, "R10 start while busy ignored", 64'(n), 3);
        chk(row_q == mrow, "R2 load while busy ignored", 64'(row_q), 64'(mrow));
        @(negedge clk);
        chk(busy == 0, "R10 no second command", 64'(busy), 0);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int o, s, d;
            if ((it % 3) == 0) do_load({$urandom, seedv} >> (it % 7));
            o = 1 + int'($urandom % 3);
            s = int'($urandom % 4);
            d = int'($urandom % 4);
            if (o == 1)
                run_cmd(2'b01, 0, d, 0, 1'($urandom % 2), "R3 random broadcast");
            else if (o == 2)
                run_cmd(2'b10, s, d, 0, 1'b0, (s == d) ? "R9 random same-slot shift" : "R6 random shift");
            else
                run_cmd(2'b11, 0, 3, int'($urandom % 4), 1'b0, "R8 random gate-shift");
        end

        finish_run();
    end

endmodule